// File: doc/BRIEF.md
# Sixteen-Bit Stack Machine Processor

This block is a small 16-bit processor that runs a fixed program read from a 24-bit-wide instruction ROM. The ROM sits outside the block and answers combinationally. The operand stack lives in an external single-port data memory and grows toward lower addresses. The core keeps only a program counter, a stack pointer and one argument register. Every push, pop, call and return goes through the data memory.

A one-cycle start pulse loads the initial program counter, stack pointer and argument. The core then fetches and executes instructions. A multi-cycle sequencer spends one cycle on each data read and one on the single write. When the program halts, the core presents a 16-bit result together with a one-cycle done pulse. A typical use is to evaluate one function of the argument, for example a recursive routine compiled to stack code, and to collect its value.

Top module: `stk16_core`

## Requirements
- R1: An instruction is 24 bits: opcode in bits 23:16, operand in bits 15:0. Opcode 1 (push constant) writes the operand at SP-1, sets SP to SP-1 and advances PC by one.
- R2: Opcode 2 (push variable) reads the word at SP+operand and pushes it in the same way as R1.
- R3: Opcode 9 (push argument) pushes the argument register loaded at start.
- R4: Opcode 3 (squeeze) reads the word at SP, writes it at SP+operand and sets SP to SP+operand.
- R5: Opcode 5 (call) writes PC+1 at SP-1, decrements SP and loads PC from the operand. Opcode 4 (return) reads the result at SP and the link at SP+1, sets SP to SP+1+operand, writes the result there and loads PC from the link.
- R6: Opcode 6 loads PC from the operand and leaves SP alone. Opcode 7 pops the top word and jumps to the operand only if that word is zero, otherwise it goes to PC+1.
- R7: Opcode 8 reads b at SP and a at SP+1, writes f(a,b) at SP+1 and sets SP to SP+1. The operand picks f:
  - 0: a+b
  - 1: a-b
  - 2: AND
  - 3: OR
  - 4: XOR
  - 16: a<b
  - 17: a>b
  - 18: a==b
  - 19: a>=b
  - 20: a<=b
  - 21: a!=b

  Comparisons are unsigned and give 1 or 0. Any other operand code gives 0.
- R8: Opcode 0 (halt) returns the word at SP. Any opcode above 9 halts and returns 0xFFFF.
- R9: At the end of a program, done is high for exactly one cycle and result carries the value. Result changes only in a cycle where done is high.
- R10: In idle, a start pulse loads PC, SP and the argument from the start inputs. A start pulse while a program runs is ignored.
- R11: Synchronous reset returns the core to idle with done low, result zero and no memory write.
- R12: Data reads return one cycle after the address is presented. An instruction makes at most one write, and two writes never occur on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin execution (taken in idle only) |
| start_pc | input | 16 | Initial program counter |
| start_sp | input | 16 | Initial stack pointer |
| start_arg | input | 16 | Argument value for push-argument |
| imem_addr | output | 16 | Instruction address (current PC) |
| imem_data | input | 24 | Instruction word, combinational from imem_addr |
| dmem_addr | output | 16 | Data memory address |
| dmem_wdata | output | 16 | Data memory write value |
| dmem_we | output | 1 | Data memory write enable |
| dmem_rdata | input | 16 | Read value for the address of the previous cycle |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Value returned by the program |

## Verification
The assertions assume that the data memory returns a read one cycle after the address and that start is pulsed for only one cycle. They also assume that reset is held across at least one rising edge before any run. The bench builds a memory with exactly this latency, drives start for one cycle from the falling edge, and applies reset before any program. Stacks are placed well above address zero, so that no program under test wraps its stack pointer.

// File: rtl/stk16_pkg.sv
package stk16_pkg;
    localparam int WORD_W  = 16;
    localparam int OPC_W   = 8;
    localparam int INSTR_W = OPC_W + WORD_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [OPC_W-1:0] {
        OP_HALT  = 8'd0,
        OP_PUSHC = 8'd1,
        OP_PUSHV = 8'd2,
        OP_SQZ   = 8'd3,
        OP_RET   = 8'd4,
        OP_CALL  = 8'd5,
        OP_JMP   = 8'd6,
        OP_JZ    = 8'd7,
        OP_ALU   = 8'd8,
        OP_PUSHA = 8'd9
    } opcode_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_RDA, ST_RDB, ST_USE, ST_WR
    } state_e;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        word_t            arg;
    } instr_t;

    localparam word_t BAD_OP_RESULT = '1;
    localparam word_t ONE           = word_t'(1);

    function automatic word_t flag(input logic b);
        return b ? ONE : '0;
    endfunction
endpackage

// File: rtl/stk16_alu.sv
module stk16_alu
    import stk16_pkg::*;
(
    input  word_t sel,
    input  word_t a,
    input  word_t b,
    output word_t y
);
    always_comb begin
        case (sel)
            16'd0:   y = a + b;
            16'd1:   y = a - b;
            16'd2:   y = a & b;
            16'd3:   y = a | b;
            16'd4:   y = a ^ b;
            16'd16:  y = flag(a <  b);
            16'd17:  y = flag(a >  b);
            16'd18:  y = flag(a == b);
            16'd19:  y = flag(a >= b);
            16'd20:  y = flag(a <= b);
            16'd21:  y = flag(a != b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/stk16_seq.sv
module stk16_seq
    import stk16_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  word_t              start_pc,
    input  word_t              start_sp,
    input  word_t              start_arg,
    output word_t              imem_addr,
    input  logic [INSTR_W-1:0] imem_data,
    output word_t              dmem_addr,
    output word_t              dmem_wdata,
    output logic               dmem_we,
    input  word_t              dmem_rdata,
    output word_t              alu_sel,
    output word_t              alu_a,
    output word_t              alu_b,
    input  word_t              alu_y,
    output logic               done,
    output word_t              result
);
    state_e state;
    word_t  pc, sp, argr, va, waddr, wval, npc, nsp;
    instr_t ir, fetched;

    assign fetched    = instr_t'(imem_data);
    assign imem_addr  = pc;
    assign dmem_we    = (state == ST_WR);
    assign dmem_wdata = wval;
    assign alu_sel    = ir.arg;
    assign alu_a      = dmem_rdata;
    assign alu_b      = va;

    always_comb begin
        case (state)
            ST_RDA:  dmem_addr = (ir.opc == OP_PUSHV) ? sp + ir.arg : sp;
            ST_RDB:  dmem_addr = sp + ONE;
            ST_WR:   dmem_addr = waddr;
            default: dmem_addr = sp;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pc <= '0; sp <= '0; argr <= '0; va <= '0;
            waddr <= '0; wval <= '0; npc <= '0; nsp <= '0;
            ir <= '0; done <= 1'b0; result <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    pc <= start_pc; sp <= start_sp; argr <= start_arg;
                    state <= ST_FETCH;
                end
                ST_FETCH: begin
                    ir <= fetched;
                    case (fetched.opc)
                        OP_HALT, OP_PUSHV, OP_SQZ, OP_RET, OP_JZ, OP_ALU:
                            state <= ST_RDA;
                        OP_PUSHC, OP_PUSHA, OP_CALL: begin
                            waddr <= sp - ONE;
                            nsp   <= sp - ONE;
                            npc   <= (fetched.opc == OP_CALL) ? fetched.arg : pc + ONE;
                            wval  <= (fetched.opc == OP_PUSHC) ? fetched.arg :
                                     (fetched.opc == OP_PUSHA) ? argr : pc + ONE;
                            state <= ST_WR;
                        end
                        OP_JMP: pc <= fetched.arg;
                        default: begin
                            result <= BAD_OP_RESULT;
                            done   <= 1'b1;
                            state  <= ST_IDLE;
                        end
                    endcase
                end
                ST_RDA: state <= (ir.opc == OP_RET || ir.opc == OP_ALU) ? ST_RDB : ST_USE;
                ST_RDB: begin
                    va    <= dmem_rdata;
                    state <= ST_USE;
                end
                ST_USE: begin
                    state <= ST_WR;
                    npc   <= pc + ONE;
                    case (ir.opc)
                        OP_HALT: begin
                            result <= dmem_rdata;
                            done   <= 1'b1;
                            state  <= ST_IDLE;
                        end
                        OP_PUSHV: begin
                            wval <= dmem_rdata; waddr <= sp - ONE; nsp <= sp - ONE;
                        end
                        OP_SQZ: begin
                            wval <= dmem_rdata; waddr <= sp + ir.arg; nsp <= sp + ir.arg;
                        end
                        OP_RET: begin
                            wval  <= va;
                            waddr <= sp + ONE + ir.arg;
                            nsp   <= sp + ONE + ir.arg;
                            npc   <= dmem_rdata;
                        end
                        OP_ALU: begin
                            wval <= alu_y; waddr <= sp + ONE; nsp <= sp + ONE;
                        end
                        OP_JZ: begin
                            sp    <= sp + ONE;
                            pc    <= (dmem_rdata == '0) ? ir.arg : pc + ONE;
                            state <= ST_FETCH;
                        end
                        default: state <= ST_FETCH;
                    endcase
                end
                ST_WR: begin
                    pc    <= npc;
                    sp    <= nsp;
                    state <= ST_FETCH;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/stk16_core.sv
module stk16_core
    import stk16_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [WORD_W-1:0]   start_pc,
    input  logic [WORD_W-1:0]   start_sp,
    input  logic [WORD_W-1:0]   start_arg,
    output logic [WORD_W-1:0]   imem_addr,
    input  logic [INSTR_W-1:0]  imem_data,
    output logic [WORD_W-1:0]   dmem_addr,
    output logic [WORD_W-1:0]   dmem_wdata,
    output logic                dmem_we,
    input  logic [WORD_W-1:0]   dmem_rdata,
    output logic                done,
    output logic [WORD_W-1:0]   result
);
    word_t alu_sel, alu_a, alu_b, alu_y;

    stk16_seq u_seq (
        .clk(clk), .rst(rst), .start(start),
        .start_pc(start_pc), .start_sp(start_sp), .start_arg(start_arg),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata),
        .alu_sel(alu_sel), .alu_a(alu_a), .alu_b(alu_b), .alu_y(alu_y),
        .done(done), .result(result)
    );

    stk16_alu u_alu (.sel(alu_sel), .a(alu_a), .b(alu_b), .y(alu_y));
endmodule

// File: rtl/stk16_core_chk.sv
module stk16_core_chk (
    input logic        clk,
    input logic        rst,
    input logic        done,
    input logic        dmem_we,
    input logic [15:0] result
);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> done);

    assert_reset_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && !dmem_we));

    assert_write_gap_R12: assert property (@(posedge clk) disable iff (rst)
        dmem_we |=> !dmem_we);

    assert_halt_no_write_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !dmem_we);
endmodule

bind stk16_core stk16_core_chk u_chk (
    .clk(clk), .rst(rst), .done(done), .dmem_we(dmem_we), .result(result)
);

// File: tb/stk16_core_test.sv
module stk16_core_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] start_pc = '0, start_sp = '0, start_arg = '0;
    logic [15:0] imem_addr, dmem_addr, dmem_wdata, dmem_rdata, result;
    logic [23:0] imem_data;
    logic        dmem_we, done;

    logic [23:0] rom [0:31];
    logic [15:0] ram [0:255];
    int nchk = 0, nerr = 0, back_to_back = 0;
    logic prev_we = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stk16_core uut (
        .clk(clk), .rst(rst), .start(start),
        .start_pc(start_pc), .start_sp(start_sp), .start_arg(start_arg),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata), .done(done), .result(result)
    );

    assign imem_data = (imem_addr < 16'd32) ? rom[imem_addr[4:0]] : 24'hFF0000;

    always @(posedge clk) begin
        if (dmem_we) ram[dmem_addr[7:0]] <= dmem_wdata;
        dmem_rdata <= ram[dmem_addr[7:0]];
    end

    function automatic logic [23:0] ins(input logic [7:0] op, input logic [15:0] arg);
        return {op, arg};
    endfunction

    function automatic logic [15:0] alu_ref(input int sel, input logic [15:0] a, input logic [15:0] b);
        case (sel)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            16: return {15'd0, a < b};
            17: return {15'd0, a > b};
            18: return {15'd0, a == b};
            19: return {15'd0, a >= b};
            20: return {15'd0, a <= b};
            21: return {15'd0, a != b};
            default: return 16'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 32; i++) rom[i] = 24'hFF0000;
    endtask

    task automatic run(input logic [15:0] pc0, input logic [15:0] a0, input int glitch_at,
                       output logic [15:0] res, output int dones);
        int quiet;
        quiet = 0; dones = 0; res = 16'hDEAD;
        @(negedge clk);
        start = 1'b1; start_pc = pc0; start_sp = 16'd200; start_arg = a0;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 20000; c++) begin
            if (c == glitch_at) begin
                start = 1'b1; start_pc = 16'd2; start_arg = 16'd3;
            end else start = 1'b0;
            @(negedge clk);
            if (dmem_we && prev_we) back_to_back++;
            prev_we = dmem_we;
            if (done) begin dones++; res = result; end
            if (dones > 0) quiet++;
            if (quiet > 3) break;
        end
        start = 1'b0;
    endtask

    task automatic load_tri();
        clear_rom();
        rom[0]  = ins(8'd9, 16'd0);
        rom[1]  = ins(8'd5, 16'd3);
        rom[2]  = ins(8'd0, 16'd0);
        rom[3]  = ins(8'd2, 16'd1);
        rom[4]  = ins(8'd7, 16'd12);
        rom[5]  = ins(8'd2, 16'd1);
        rom[6]  = ins(8'd2, 16'd2);
        rom[7]  = ins(8'd1, 16'd1);
        rom[8]  = ins(8'd8, 16'd1);
        rom[9]  = ins(8'd5, 16'd3);
        rom[10] = ins(8'd8, 16'd0);
        rom[11] = ins(8'd6, 16'd13);
        rom[12] = ins(8'd1, 16'd0);
        rom[13] = ins(8'd4, 16'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [15:0] r;
        int d;
        logic [15:0] va [0:4];
        logic [15:0] vb [0:4];
        va = '{16'd5, 16'd3, 16'd7, 16'd0, 16'hFFFF};
        vb = '{16'd3, 16'd5, 16'd7, 16'hFFFF, 16'd1};
        for (int i = 0; i < 256; i++) ram[i] = 16'h0;

        repeat (3) @(negedge clk);
        chk("R11 done in reset", {15'd0, done}, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 done after reset", {15'd0, done}, 16'd0);
        chk("R11 no write after reset", {15'd0, dmem_we}, 16'd0);
        chk("R11 result after reset", result, 16'd0);

        // R2 R3 R5 R6: recursive sum 0..n
        load_tri();
        for (int n = 0; n <= 12; n++) begin
            run(16'd0, 16'(n), -1, r, d);
            chk("R2 R3 R5 R6 recursive sum", r, 16'(n * (n + 1) / 2));
            chk("R9 single done pulse", 16'(d), 16'd1);
        end

        // R10: start while running is ignored
        run(16'd0, 16'd10, 25, r, d);
        chk("R10 mid-run start ignored", r, 16'd55);
        // R10: start loads pc and sp (halt at 2 returns mem[200])
        ram[200] = 16'h1234;
        run(16'd2, 16'd0, -1, r, d);
        chk("R10 R8 start pc/sp loaded, halt reads SP", r, 16'h1234);

        // R7 R1: ALU sweep over all codes 0..23
        clear_rom();
        rom[3] = ins(8'd0, 16'd0);
        for (int p = 0; p < 5; p++) begin
            for (int s = 0; s < 24; s++) begin
                rom[0] = ins(8'd1, va[p]);
                rom[1] = ins(8'd1, vb[p]);
                rom[2] = ins(8'd8, 16'(s));
                run(16'd0, 16'd0, -1, r, d);
                chk($sformatf("R7 R1 alu sel=%0d a=%h b=%h", s, va[p], vb[p]), r, alu_ref(s, va[p], vb[p]));
            end
        end

        // R4 squeeze
        clear_rom();
        rom[0] = ins(8'd1, 16'd11);
        rom[1] = ins(8'd1, 16'd22);
        rom[2] = ins(8'd1, 16'd33);
        rom[3] = ins(8'd3, 16'd1);
        rom[4] = ins(8'd8, 16'd0);
        rom[5] = ins(8'd0, 16'd0);
        run(16'd0, 16'd0, -1, r, d);
        chk("R4 squeeze 1 then add", r, 16'd44);
        rom[3] = ins(8'd3, 16'd2);
        rom[4] = ins(8'd0, 16'd0);
        run(16'd0, 16'd0, -1, r, d);
        chk("R4 squeeze 2 keeps top", r, 16'd33);

        // R2 push variable
        clear_rom();
        rom[0] = ins(8'd1, 16'd7);
        rom[1] = ins(8'd1, 16'd8);
        rom[2] = ins(8'd2, 16'd1);
        rom[3] = ins(8'd8, 16'd1);
        rom[4] = ins(8'd0, 16'd0);
        run(16'd0, 16'd0, -1, r, d);
        chk("R2 push variable offset", r, 16'd1);

        // R3 push argument
        clear_rom();
        rom[0] = ins(8'd9, 16'd0);
        rom[1] = ins(8'd0, 16'd0);
        run(16'd0, 16'hBEEF, -1, r, d);
        chk("R3 push argument", r, 16'hBEEF);

        // R6 jump-if-zero both ways, plain jump
        clear_rom();
        rom[1] = ins(8'd7, 16'd4);
        rom[2] = ins(8'd1, 16'd9);
        rom[3] = ins(8'd0, 16'd0);
        rom[4] = ins(8'd1, 16'd5);
        rom[5] = ins(8'd0, 16'd0);
        rom[0] = ins(8'd1, 16'd0);
        run(16'd0, 16'd0, -1, r, d);
        chk("R6 jz taken", r, 16'd5);
        rom[0] = ins(8'd1, 16'd3);
        run(16'd0, 16'd0, -1, r, d);
        chk("R6 jz not taken", r, 16'd9);
        clear_rom();
        rom[0] = ins(8'd6, 16'd3);
        rom[1] = ins(8'd1, 16'd1);
        rom[2] = ins(8'd0, 16'd0);
        rom[3] = ins(8'd1, 16'd2);
        rom[4] = ins(8'd0, 16'd0);
        run(16'd0, 16'd0, -1, r, d);
        chk("R6 jump", r, 16'd2);

        // R8 undefined opcodes
        clear_rom();
        rom[0] = ins(8'd10, 16'd0);
        run(16'd0, 16'd0, -1, r, d);
        chk("R8 opcode 10", r, 16'hFFFF);
        chk("R9 single done on bad opcode", 16'(d), 16'd1);
        rom[0] = ins(8'd1, 16'd4);
        rom[1] = ins(8'hFF, 16'd0);
        run(16'd0, 16'd0, -1, r, d);
        chk("R8 opcode 0xFF", r, 16'hFFFF);

        chk("R12 no consecutive writes", 16'(back_to_back), 16'd0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule